// File: doc/BRIEF.md
# Exception Return Stack Sequencer

This block carries out the two stack-return instructions of a CPU with a 16-bit data word. Both of them pop a three-word frame (status word plus a 32-bit program counter) from the stack through a word-wide read port with a request/acknowledge handshake. The privileged variant restores the popped status as it is. The restore variant keeps the live supervisor bit. After the frame has been consumed, the block fetches the first two instruction words at the new program counter and then signals completion.

The surrounding core pulses `start_i` with the opcode, the live status word and the stack pointer. It then waits for `done_o`. When `done_o` arrives without `priv_err_o`, the core takes the new status, program counter, stack pointer and the two prefetched words. When `priv_err_o` accompanies `done_o`, the core raises a privilege exception instead. In that case no memory traffic has taken place and the outputs have not moved.

Top module: `xret_sequencer`

## Requirements
- R1: Only opcode 0x4E73 (privileged return) and opcode 0x4E77 (restore return, keeps privilege) start a sequence. A start with any other opcode issues no read and gives no `done_o`.
- R2: If 0x4E73 is started while bit 13 of `sr_i` is 0, the block issues no read. `done_o` and `priv_err_o` are both high for the single cycle after the start edge, and `sr_o`, `pc_o` and `sp_o` keep their values.
- R3: A sequence reads exactly five words, at these addresses in this order: SP+2, SP, SP+4, new PC, new PC+2. SP is `sp_i` sampled at start, and all addresses are byte addresses.
- R4: `rd_req_o` and `rd_addr_o` stay unchanged while a read waits for `rd_ack_i`. Read data is taken only in a cycle where `rd_ack_i` is high.
- R5: On the clock edge that accepts the third frame read, `sr_o`, `pc_o` and `sp_o` update together. The new `pc_o` is {word from SP+2, word from SP+4} and the new `sp_o` is SP+6. Before that edge they hold their old values.
- R6: For 0x4E73, `sr_o` takes the word read from SP unchanged.
- R7: For 0x4E77, `sr_o` takes the word read from SP, except that bit 13 takes the value of bit 13 of `sr_i` at start.
- R8: `pf0_o` and `pf1_o` hold the words read at new PC and new PC+2. `done_o` is high for exactly one cycle, on the edge after the second prefetch read is acknowledged.
- R9: A start while a sequence is in progress is ignored. It adds no read and changes no result.
- R10: While `rst_ni` is low, the block is idle with `rd_req_o` low, `done_o` and `priv_err_o` low, and all result outputs zero. The block issues no request while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| opcode_i | input | 16 | Instruction opcode |
| sr_i | input | 16 | Live status word |
| sp_i | input | 32 | Live stack pointer |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read byte address |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_data_i | input | 16 | Read data, valid with acknowledge |
| sr_o | output | 16 | New status word |
| pc_o | output | 32 | New program counter |
| sp_o | output | 32 | New stack pointer |
| pf0_o | output | 16 | First prefetched instruction word |
| pf1_o | output | 16 | Second prefetched instruction word |
| done_o | output | 1 | One-cycle completion pulse |
| priv_err_o | output | 1 | Privilege violation, with done |

## Verification
The bench logs every acknowledged address. It catches a design that reads the frame in ascending order, which would swap the status word and the high half of the program counter, and a design that prefetches from the stale counter. It gives the restore variant a popped status whose bit 13 disagrees with the live one, in both directions, so a design that commits the popped bit or ignores the variant shows the wrong status. It adds slow acknowledges, undefined-looking data between acknowledges, a start pulse mid-sequence and a reset mid-sequence. These expose capture without acknowledge, address drift while waiting, restarts and early commits. A privileged return from user mode must produce its error pulse with no bus traffic and untouched outputs.

// File: rtl/xret_pkg.sv
package xret_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PCH,
    ST_SR,
    ST_PCL,
    ST_PF0,
    ST_PF1
  } xret_st_e;

  localparam logic [15:0] OPC_XRET_PRIV = 16'h4E73;
  localparam logic [15:0] OPC_XRET_KEEP = 16'h4E77;
  localparam int unsigned SUP_BIT       = 13;
endpackage

// File: rtl/xret_decode.sv
module xret_decode
  import xret_pkg::*;
(
  input  logic [15:0] opcode_i,
  output logic        valid_o,
  output logic        priv_o,
  output logic        keep_o
);
  assign priv_o  = (opcode_i == OPC_XRET_PRIV);
  assign keep_o  = (opcode_i == OPC_XRET_KEEP);
  assign valid_o = priv_o | keep_o;
endmodule

// File: rtl/xret_addr_gen.sv
module xret_addr_gen
  import xret_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = 2 * DW
) (
  input  xret_st_e        st_i,
  input  logic [AW-1:0]   sp_base_i,
  input  logic [AW-1:0]   pc_new_i,
  output logic            req_o,
  output logic [AW-1:0]   addr_o
);
  localparam logic [AW-1:0] WORD_B = AW'(DW / 8);

  // frame is read out of address order: PC high, SR, PC low
  always_comb begin
    req_o  = 1'b1;
    addr_o = '0;
    unique case (st_i)
      ST_PCH:  addr_o = sp_base_i + WORD_B;
      ST_SR:   addr_o = sp_base_i;
      ST_PCL:  addr_o = sp_base_i + 2 * WORD_B;
      ST_PF0:  addr_o = pc_new_i;
      ST_PF1:  addr_o = pc_new_i + WORD_B;
      default: req_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/xret_sr_merge.sv
module xret_sr_merge #(
  parameter int unsigned DW      = 16,
  parameter int unsigned SUP_POS = 13
) (
  input  logic [DW-1:0] popped_i,
  input  logic          keep_i,
  input  logic          sup_now_i,
  output logic [DW-1:0] sr_o
);
  always_comb begin
    sr_o = popped_i;
    if (keep_i) sr_o[SUP_POS] = sup_now_i;
  end
endmodule

// File: rtl/xret_sequencer.sv
module xret_sequencer
  import xret_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [15:0]   opcode_i,
  input  logic [DW-1:0] sr_i,
  input  logic [AW-1:0] sp_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] sr_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic [DW-1:0] pf0_o,
  output logic [DW-1:0] pf1_o,
  output logic          done_o,
  output logic          priv_err_o
);
  localparam logic [AW-1:0] FRAME_B = AW'(3 * (DW / 8));

  xret_st_e      st_q;
  logic [AW-1:0] sp_base_q;
  logic          keep_q, sup_q;
  logic [DW-1:0] pch_q, sr_pop_q, sr_q, pf0_q, pf1_q;
  logic [AW-1:0] pc_q, sp_q;
  logic          done_q, perr_q;

  logic          dec_valid, dec_priv, dec_keep;
  logic          go, priv_fail;
  logic [DW-1:0] sr_merged;
  logic          unused_sr;

  assign unused_sr = ^(sr_i & ~(DW'(1) << SUP_BIT));

  xret_decode i_decode (
    .opcode_i (opcode_i),
    .valid_o  (dec_valid),
    .priv_o   (dec_priv),
    .keep_o   (dec_keep)
  );

  xret_addr_gen #(.DW(DW)) i_addr_gen (
    .st_i      (st_q),
    .sp_base_i (sp_base_q),
    .pc_new_i  (pc_q),
    .req_o     (rd_req_o),
    .addr_o    (rd_addr_o)
  );

  xret_sr_merge #(.DW(DW), .SUP_POS(SUP_BIT)) i_sr_merge (
    .popped_i  (sr_pop_q),
    .keep_i    (keep_q),
    .sup_now_i (sup_q),
    .sr_o      (sr_merged)
  );

  assign go        = start_i && (st_q == ST_IDLE) && dec_valid;
  assign priv_fail = dec_priv && !sr_i[SUP_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sp_base_q <= '0;
      keep_q    <= 1'b0;
      sup_q     <= 1'b0;
      pch_q     <= '0;
      sr_pop_q  <= '0;
      sr_q      <= '0;
      pc_q      <= '0;
      sp_q      <= '0;
      pf0_q     <= '0;
      pf1_q     <= '0;
      done_q    <= 1'b0;
      perr_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      perr_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (go) begin
          if (priv_fail) begin
            done_q <= 1'b1;
            perr_q <= 1'b1;
          end else begin
            st_q      <= ST_PCH;
            sp_base_q <= sp_i;
            keep_q    <= dec_keep;
            sup_q     <= sr_i[SUP_BIT];
          end
        end
        ST_PCH: if (rd_ack_i) begin
          pch_q <= rd_data_i;
          st_q  <= ST_SR;
        end
        ST_SR: if (rd_ack_i) begin
          sr_pop_q <= rd_data_i;
          st_q     <= ST_PCL;
        end
        ST_PCL: if (rd_ack_i) begin
          // architectural state commits as one
          sr_q <= sr_merged;
          pc_q <= {pch_q, rd_data_i};
          sp_q <= sp_base_q + FRAME_B;
          st_q <= ST_PF0;
        end
        ST_PF0: if (rd_ack_i) begin
          pf0_q <= rd_data_i;
          st_q  <= ST_PF1;
        end
        ST_PF1: if (rd_ack_i) begin
          pf1_q  <= rd_data_i;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sr_o       = sr_q;
  assign pc_o       = pc_q;
  assign sp_o       = sp_q;
  assign pf0_o      = pf0_q;
  assign pf1_o      = pf1_q;
  assign done_o     = done_q;
  assign priv_err_o = perr_q;
endmodule

// File: rtl/xret_sva.sv
module xret_sva
  import xret_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [15:0]   opcode_i,
  input logic          sup_live_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          sr_sup_o,
  input logic [DW-1:0] sr_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] sp_o,
  input logic          done_o,
  input logic          priv_err_o,
  input logic          busy_i,
  input logic          keep_i,
  input logic          sup_i
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_PRIV_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && start_i && opcode_i == OPC_XRET_PRIV && !sup_live_i
      |=> done_o && priv_err_o && !rd_req_o); // R2

  AST_PRIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_err_o |-> $stable(sr_o) && $stable(pc_o) && $stable(sp_o)); // R2

  AST_BAD_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && start_i && opcode_i != OPC_XRET_PRIV && opcode_i != OPC_XRET_KEEP
      |=> !rd_req_o && !done_o); // R1

  AST_KEEP_SUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !priv_err_o && keep_i |-> sr_sup_o == sup_i); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !rd_req_o); // R10
endmodule

bind xret_sequencer xret_sva #(.DW(DW)) i_xret_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .opcode_i   (opcode_i),
  .sup_live_i (sr_i[xret_pkg::SUP_BIT]),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_ack_i   (rd_ack_i),
  .sr_sup_o   (sr_o[xret_pkg::SUP_BIT]),
  .sr_o       (sr_o),
  .pc_o       (pc_o),
  .sp_o       (sp_o),
  .done_o     (done_o),
  .priv_err_o (priv_err_o),
  .busy_i     (st_q != xret_pkg::ST_IDLE),
  .keep_i     (keep_q),
  .sup_i      (sup_q)
);

// File: tb/test_xret_sequencer.sv
`timescale 1ns/1ps
module test_xret_sequencer;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i;
  logic [15:0] opcode_i;
  logic [15:0] sr_i;
  logic [31:0] sp_i;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_ack_i;
  logic [15:0] rd_data_i;
  logic [15:0] sr_o;
  logic [31:0] pc_o;
  logic [31:0] sp_o;
  logic [15:0] pf0_o;
  logic [15:0] pf1_o;
  logic        done_o;
  logic        priv_err_o;

  always #2.5 clk_i = ~clk_i;

  xret_sequencer i_xret_sequencer (.*);

  int n_checks = 0;
  int n_errs   = 0;

  // memory responder state
  int          lat = 0;
  int          wcnt = 0;
  int          n_acks = 0;
  int          hold_err = 0;
  logic [31:0] hold_a;
  logic [31:0] alog [8];
  logic [31:0] fsp;
  logic [15:0] fr_pch, fr_sr, fr_pcl;

  function automatic logic [15:0] mem(input logic [31:0] a);
    if (a == fsp + 32'd2) return fr_pch;
    if (a == fsp)         return fr_sr;
    if (a == fsp + 32'd4) return fr_pcl;
    return a[15:0] ^ 16'h3C5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    rd_ack_i  = 1'b0;
    rd_data_i = 16'hDEAD;
    forever begin
      @(negedge clk_i);
      if (rd_ack_i) begin
        rd_ack_i  = 1'b0;
        rd_data_i = 16'hDEAD;
        wcnt      = 0;
      end else if (rd_req_o) begin
        if (wcnt == 0) hold_a = rd_addr_o;
        else if (rd_addr_o !== hold_a) hold_err++;
        if (wcnt >= lat) begin
          rd_ack_i  = 1'b1;
          rd_data_i = mem(rd_addr_o);
          if (n_acks < 8) alog[n_acks] = rd_addr_o;
          n_acks++;
        end else begin
          wcnt++;
          rd_data_i = 16'hBEEF ^ 16'(wcnt);
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  task automatic run_op(input logic [15:0] opc, input logic [15:0] sr,
                        input logic [31:0] sp, input logic [15:0] pch,
                        input logic [15:0] psr, input logic [15:0] pcl,
                        input int l, input bit poke);
    logic [31:0] pc_e, sp_e, sp_old;
    logic [15:0] sr_e;
    bit done_seen, commit_seen, early_seen, perr;
    sp_old = sp_o;
    fsp = sp; fr_pch = pch; fr_sr = psr; fr_pcl = pcl;
    lat = l; n_acks = 0; hold_err = 0;
    pc_e = {pch, pcl};
    sp_e = sp + 32'd6;
    sr_e = psr;
    if (opc == 16'h4E77) sr_e[13] = sr[13];
    done_seen = 0; commit_seen = 0; early_seen = 0; perr = 0;
    @(negedge clk_i);
    opcode_i = opc; sr_i = sr; sp_i = sp; start_i = 1'b1;
    for (int c = 0; c < 300 && !done_seen; c++) begin
      @(posedge clk_i); #1;
      if (c == 0) start_i = 1'b0;
      if (poke && c == 4) begin
        start_i = 1'b1; opcode_i = 16'h4E73; sr_i = 16'h2000; sp_i = sp + 32'd100;
      end
      if (poke && c == 5) start_i = 1'b0;
      if (n_acks == 2 && !early_seen) begin
        early_seen = 1;
        chk(sp_o == sp_old, "R5", "sp before commit", sp_o, sp_old);
      end
      if (n_acks == 3 && !commit_seen) begin
        commit_seen = 1;
        chk(pc_o == pc_e, "R5", "pc at commit", pc_o, pc_e);
        chk(sp_o == sp_e, "R5", "sp at commit", sp_o, sp_e);
        chk(sr_o == sr_e, (opc == 16'h4E77) ? "R7" : "R6", "sr at commit", 32'(sr_o), 32'(sr_e));
      end
      if (done_o) begin
        done_seen = 1;
        perr = priv_err_o;
        chk(n_acks == 5, "R8", "reads before done", n_acks, 5);
      end
    end
    chk(done_seen, "R8", "done seen", 32'(done_seen), 1);
    chk(!perr, "R2", "no priv flag", 32'(perr), 0);
    chk(alog[0] == sp + 32'd2, "R3", "read0 addr", alog[0], sp + 32'd2);
    chk(alog[1] == sp,         "R3", "read1 addr", alog[1], sp);
    chk(alog[2] == sp + 32'd4, "R3", "read2 addr", alog[2], sp + 32'd4);
    chk(alog[3] == pc_e,       "R3", "read3 addr", alog[3], pc_e);
    chk(alog[4] == pc_e + 32'd2, "R3", "read4 addr", alog[4], pc_e + 32'd2);
    chk(pf0_o == mem(pc_e), "R8", "pf0", 32'(pf0_o), 32'(mem(pc_e)));
    chk(pf1_o == mem(pc_e + 32'd2), "R8", "pf1", 32'(pf1_o), 32'(mem(pc_e + 32'd2)));
    chk(hold_err == 0, "R4", "addr held while waiting", hold_err, 0);
    @(posedge clk_i); #1;
    chk(!done_o, "R8", "done one cycle", 32'(done_o), 0);
    repeat (8) @(posedge clk_i);
    #1;
    chk(n_acks == 5, poke ? "R9" : "R3", "no further reads", n_acks, 5);
    chk(sp_o == sp_e, poke ? "R9" : "R5", "sp stays", sp_o, sp_e);
  endtask

  task automatic priv_violation;
    logic [15:0] sr0; logic [31:0] pc0, sp0;
    sr0 = sr_o; pc0 = pc_o; sp0 = sp_o; n_acks = 0;
    @(negedge clk_i);
    opcode_i = 16'h4E73; sr_i = 16'h0700; sp_i = 32'h0000_3000; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    chk(done_o && priv_err_o, "R2", "done+priv pulse", {30'd0, done_o, priv_err_o}, 3);
    @(posedge clk_i); #1;
    chk(!done_o && !priv_err_o, "R2", "pulse one cycle", {30'd0, done_o, priv_err_o}, 0);
    repeat (6) @(posedge clk_i);
    #1;
    chk(n_acks == 0, "R2", "no reads", n_acks, 0);
    chk(sr_o == sr0 && pc_o == pc0, "R2", "sr/pc unchanged", pc_o, pc0);
    chk(sp_o == sp0, "R2", "sp unchanged", sp_o, sp0);
  endtask

  task automatic bad_opcode(input logic [15:0] opc);
    bit any_done;
    any_done = 0; n_acks = 0;
    @(negedge clk_i);
    opcode_i = opc; sr_i = 16'h2700; sp_i = 32'h0000_4000; start_i = 1'b1;
    for (int c = 0; c < 10; c++) begin
      @(posedge clk_i); #1;
      start_i = 1'b0;
      if (done_o || rd_req_o) any_done = 1;
    end
    chk(!any_done, "R1", "no activity for other opcode", 32'(any_done), 0);
    chk(n_acks == 0, "R1", "no reads for other opcode", n_acks, 0);
  endtask

  task automatic reset_mid;
    n_acks = 0; fsp = 32'h0000_5000; lat = 2;
    @(negedge clk_i);
    opcode_i = 16'h4E77; sr_i = 16'h0000; sp_i = 32'h0000_5000; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    for (int c = 0; c < 50 && n_acks < 1; c++) begin
      @(posedge clk_i); #1;
    end
    rst_ni = 1'b0;
    #1;
    chk(!rd_req_o, "R10", "req low in reset", 32'(rd_req_o), 0);
    chk(sp_o == 0 && pc_o == 0, "R10", "outputs cleared", sp_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n_acks = 0;
    repeat (6) @(posedge clk_i);
    #1;
    chk(n_acks == 0 && !rd_req_o, "R10", "idle after reset", n_acks, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; opcode_i = '0; sr_i = '0; sp_i = '0;
    fsp = 32'hFFFF_0000; fr_pch = '0; fr_sr = '0; fr_pcl = '0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(!rd_req_o && !done_o && !priv_err_o, "R10", "reset quiet",
        {29'd0, rd_req_o, done_o, priv_err_o}, 0);
    chk(sr_o == 0 && sp_o == 0 && pc_o == 0, "R10", "reset outputs", sp_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // privileged return, fast memory
    run_op(16'h4E73, 16'h2700, 32'h0000_1000, 16'h0001, 16'h2704, 16'h2000, 0, 0);
    // privileged return, slow memory, popped user mode
    run_op(16'h4E73, 16'h2000, 32'h0000_8F00, 16'h0002, 16'h0015, 16'h4442, 3, 0);
    // restore from user: popped bit 13 set must be cleared
    run_op(16'h4E77, 16'h0010, 32'h0000_2200, 16'h0003, 16'h2715, 16'h1000, 1, 0);
    // restore from supervisor: popped bit 13 clear must be set
    run_op(16'h4E77, 16'h2000, 32'h0000_2400, 16'h0004, 16'h001F, 16'h0600, 0, 0);
    priv_violation();
    bad_opcode(16'h4E75);
    bad_opcode(16'h4E72);
    // start pulse mid-sequence
    run_op(16'h4E73, 16'h2300, 32'h0000_6000, 16'h0005, 16'h2311, 16'h0100, 2, 1);
    reset_mid();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule